// File: doc/BRIEF.md
# Word-Packed Transmit/Receive FIFO Controller

This block holds the data path between a register bus and a serial packet engine. It keeps one transmit queue, filled from a write port on the register side and drained by the engine. It also keeps one receive queue, filled by the engine and drained by register reads. Each entry is a 32-bit word that carries up to four payload bytes.

A control byte holds one self-clearing flush request per queue and one trigger threshold per queue. A status byte reports the number of free transmit slots and the number of receive words waiting. Two level outputs tell the interrupt unit when each queue wants service. A write into a full transmit queue and a read from an empty receive queue each raise a one-cycle error pulse.

Top module: `word_fifo_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80 (8 free transmit slots, 0 receive words), the control byte reads 0x00, tx_req is 1, and rx_req, tx_valid, tx_ovf and rx_udf are 0.
- R2: Words written on tx_wr_en in consecutive cycles are each accepted in one cycle. The engine sees them on tx_rdata in write order with every bit unchanged, so a final partial word keeps its first byte in bits 7:0. tx_pop advances to the next word.
- R3: Words pushed by the engine appear on rx_rdata in push order. rx_rdata shows the oldest word combinationally, and rx_rd_en removes it at the clock edge.
- R4: Status bits 7:4 hold the free transmit slots (depth minus occupancy) and bits 3:0 hold the receive words available. Both reflect a push or pop from the cycle after it.
- R5: Writing control bit 1 flushes the transmit queue and writing bit 0 flushes the receive queue. The bit reads back 1 in the cycle after the write. One cycle later it reads 0 and the queue is empty.
- R6: A transmit write, transmit pop, receive push or receive read issued while the corresponding flush bit reads 1 is ignored.
- R7: Control bits 7:5 set the transmit trigger and bits 4:2 set the receive trigger. Both read back unchanged. A control write with a flush bit at 0 does not cancel a pending flush.
- R8: tx_req is 1 exactly while the free transmit count exceeds the transmit trigger. rx_req is 1 exactly while the receive count exceeds the receive trigger.
- R9: A transmit write while the queue holds 8 words is dropped. The stored words are unchanged, and tx_ovf is 1 for exactly the following cycle.
- R10: A receive read while the receive queue is empty sees rx_rdata equal to 0. It changes no count, and rx_udf is 1 for exactly the following cycle.
- R11: An engine pop on an empty transmit queue and an engine push into a full receive queue are ignored and leave the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_en | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| ctrl_rdata | output | 8 | Control byte readback |
| status | output | 8 | {tx free slots, rx words available} |
| tx_wr_en | input | 1 | Transmit word write strobe (register side) |
| tx_wdata | input | 32 | Transmit word |
| tx_pop | input | 1 | Engine takes the oldest transmit word |
| tx_rdata | output | 32 | Oldest transmit word |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Engine stores a receive word |
| rx_pdata | input | 32 | Receive word from the engine |
| rx_rd_en | input | 1 | Register-side read of the receive queue |
| rx_rdata | output | 32 | Oldest receive word, zero when empty |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| tx_ovf | output | 1 | Transmit overflow pulse |
| rx_udf | output | 1 | Receive underflow pulse |

## Verification
The queues are exercised with back-to-back transmit bursts, a single partial word, fills to exactly eight words, and one word beyond that. These patterns separate correct ordering from lost or duplicated entries, and they show whether the full boundary drops the excess word or corrupts storage. The trigger comparison is stepped across the threshold, one word at a time, in both directions. This catches greater-or-equal mistakes and swapped fields. Flushes are issued on loaded queues while pushes and pops arrive in the same flush cycle. This shows whether the self-clearing bit, the emptying and the ignored traffic line up cycle by cycle.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
  localparam int CTRL_W = 8;
  localparam int TRIG_W = 3;
  localparam int STAT_W = 4;

  typedef struct packed {
    logic [TRIG_W-1:0] tx_trig;
    logic [TRIG_W-1:0] rx_trig;
    logic              tx_flush;
    logic              rx_flush;
  } ctrl_t;
endpackage

// File: rtl/wfc_fifo.sv
module wfc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_nx, rd_ptr, rd_ptr_nx;
  logic [CW-1:0] cnt_nx;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = count;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      cnt_nx    = '0;
    end else begin
      if (do_push) wr_ptr_nx = bump(wr_ptr);
      if (do_pop)  rd_ptr_nx = bump(rd_ptr);
      if (do_push && !do_pop)      cnt_nx = count + CW'(1);
      else if (!do_push && do_pop) cnt_nx = count - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // R4: occupancy never exceeds the depth
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5: a flush cycle leaves the queue empty
  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R9: a push into a full queue without a pop keeps it at depth
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));
  // R11: a pop on an empty queue leaves it empty unless something is pushed
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/wfc_ctrl.sv
module wfc_ctrl
  import wfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [TRIG_W-1:0] rx_trig
);
  ctrl_t cur, nxt, wr;

  assign wr = ctrl_t'(wdata);

  always_comb begin
    nxt          = cur;
    // a flush bit lives for exactly one cycle unless requested again
    nxt.tx_flush = 1'b0;
    nxt.rx_flush = 1'b0;
    if (wr_en) begin
      nxt.tx_trig  = wr.tx_trig;
      nxt.rx_trig  = wr.rx_trig;
      nxt.tx_flush = wr.tx_flush;
      nxt.rx_flush = wr.rx_flush;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  assign rdata    = CTRL_W'(cur);
  assign tx_flush = cur.tx_flush;
  assign rx_flush = cur.rx_flush;
  assign tx_trig  = cur.tx_trig;
  assign rx_trig  = cur.rx_trig;

  // R5: the transmit flush bit clears itself after one cycle
  p_txflush_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !(wr_en && wdata[1])) |=> !tx_flush);
  // R5: the receive flush bit clears itself after one cycle
  p_rxflush_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush && !(wr_en && wdata[0])) |=> !rx_flush);
  // R7: trigger fields hold without a control write
  p_trig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(tx_trig) && $stable(rx_trig)));
endmodule

// File: rtl/wfc_status.sv
module wfc_status
  import wfc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int CMPW = (CW > TRIG_W) ? CW : TRIG_W
) (
  input  logic [CW-1:0]       tx_count,
  input  logic [CW-1:0]       rx_count,
  input  logic [TRIG_W-1:0]   tx_trig,
  input  logic [TRIG_W-1:0]   rx_trig,
  output logic [2*STAT_W-1:0] status,
  output logic                tx_req,
  output logic                rx_req
);
  logic [CW-1:0] tx_free;

  assign tx_free = CW'(DEPTH) - tx_count;
  assign status  = {STAT_W'(tx_free), STAT_W'(rx_count)};
  assign tx_req  = CMPW'(tx_free)  > CMPW'(tx_trig);
  assign rx_req  = CMPW'(rx_count) > CMPW'(rx_trig);

  always_comb begin
    // R8: with a zero trigger any free slot must request data
    p_txreq_zero_r8: assert ((tx_trig != '0) || (tx_free == '0) || tx_req);
  end
endmodule

// File: rtl/word_fifo_ctrl.sv
module word_fifo_ctrl
  import wfc_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_en,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  output logic [7:0]        status,
  input  logic              tx_wr_en,
  input  logic [W-1:0]      tx_wdata,
  input  logic              tx_pop,
  output logic [W-1:0]      tx_rdata,
  output logic              tx_valid,
  input  logic              rx_push,
  input  logic [W-1:0]      rx_pdata,
  input  logic              rx_rd_en,
  output logic [W-1:0]      rx_rdata,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_ovf,
  output logic              rx_udf
);
  logic              tx_flush, rx_flush;
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic [CW-1:0]     tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [W-1:0]      rx_head;
  logic              ovf_nx, udf_nx;

  wfc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr_en), .wdata(ctrl_wdata),
    .rdata(ctrl_rdata), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .tx_trig(tx_trig), .rx_trig(rx_trig)
  );

  wfc_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_wr_en), .push_data(tx_wdata), .pop(tx_pop),
    .head(tx_rdata), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  wfc_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .push_data(rx_pdata), .pop(rx_rd_en),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  wfc_status #(.DEPTH(DEPTH)) u_stat (
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_trig(tx_trig), .rx_trig(rx_trig),
    .status(status), .tx_req(tx_req), .rx_req(rx_req)
  );

  assign tx_valid = !tx_empty && !tx_flush;
  assign rx_rdata = (rx_empty || rx_flush) ? '0 : rx_head;

  always_comb begin
    ovf_nx = tx_wr_en && tx_full && !tx_flush;
    udf_nx = rx_rd_en && rx_empty && !rx_flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_udf <= 1'b0;
    end else begin
      tx_ovf <= ovf_nx;
      rx_udf <= udf_nx;
    end
  end

  // R9: an overflow pulse follows a transmit write
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |-> $past(tx_wr_en));
  // R10: an underflow pulse follows a receive read
  p_udf_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_udf |-> $past(rx_rd_en));
  // R10: an empty receive queue presents zero data
  p_udf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:0] == 4'd0) |-> (rx_rdata == '0));
endmodule

// File: tb/word_fifo_ctrl_test.sv
module word_fifo_ctrl_test;
  logic        clk, rst_n;
  logic        ctrl_wr_en;
  logic [7:0]  ctrl_wdata, ctrl_rdata, status;
  logic        tx_wr_en, tx_pop, tx_valid, rx_push, rx_rd_en;
  logic [31:0] tx_wdata, tx_rdata, rx_pdata, rx_rdata;
  logic        tx_req, rx_req, tx_ovf, rx_udf;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  word_fifo_ctrl uut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ctrl_wr_en = 0; ctrl_wdata = 0; tx_wr_en = 0; tx_wdata = 0; tx_pop = 0;
    rx_push = 0; rx_pdata = 0; rx_rd_en = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_wr_en = 1; ctrl_wdata = v;
    cyc();
  endtask

  task automatic tx_put(input logic [31:0] v);
    tx_wr_en = 1; tx_wdata = v;
    cyc();
  endtask

  task automatic rx_put(input logic [31:0] v);
    rx_push = 1; rx_pdata = v;
    cyc();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h80);
    chk("R1 ctrl", ctrl_rdata, 0);
    chk("R1 tx_req", tx_req, 1);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 pulses", {tx_ovf, rx_udf}, 0);
  endtask

  task automatic t_tx_order();
    tx_wdata = 32'h11223344; tx_wr_en = 1; @(negedge clk);
    tx_wdata = 32'hA5A5_0001;             @(negedge clk);
    tx_wdata = 32'h0000_00C3;             // partial word, one byte in lane 0
    cyc();
    chk("R4 status after 3 tx", status, 32'h50);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] e;
      e = (i == 0) ? 32'h11223344 : (i == 1) ? 32'hA5A5_0001 : 32'h0000_00C3;
      chk("R2 tx order", tx_rdata, e);
      chk("R2 tx_valid", tx_valid, 1);
      tx_pop = 1;
      cyc();
    end
    chk("R4 tx drained", status, 32'h80);
    tx_pop = 1; cyc();
    chk("R11 pop empty tx", status, 32'h80);
    chk("R11 tx_valid", tx_valid, 0);
  endtask

  task automatic t_rx_order();
    for (int i = 0; i < 4; i++) rx_put(32'hBEEF_0000 + i);
    chk("R4 rx count", status, 32'h84);
    for (int i = 0; i < 4; i++) begin
      chk("R3 rx order", rx_rdata, 32'hBEEF_0000 + i);
      rx_rd_en = 1;
      cyc();
    end
    chk("R4 rx drained", status, 32'h80);
    chk("R10 no pulse on valid reads", rx_udf, 0);
  endtask

  task automatic t_trig();
    wr_ctrl(8'hA8);                     // tx trig 5, rx trig 2
    chk("R7 readback", ctrl_rdata, 32'hA8);
    chk("R8 tx_req 8>5", tx_req, 1);
    for (int i = 0; i < 3; i++) tx_put(32'h100 + i);
    chk("R8 tx_req 5>5", tx_req, 0);
    tx_pop = 1; cyc();
    chk("R8 tx_req 6>5", tx_req, 1);
    rx_put(1); rx_put(2);
    chk("R8 rx_req 2>2", rx_req, 0);
    rx_put(3);
    chk("R8 rx_req 3>2", rx_req, 1);
  endtask

  task automatic t_flush();
    // tx holds 2 words, rx holds 3 words here
    chk("R5 pre-flush status", status, 32'h63);
    wr_ctrl(8'hAB);
    chk("R5 flush bits read 1", ctrl_rdata, 32'hAB);
    tx_wr_en = 1; tx_wdata = 32'hDEAD; rx_push = 1; rx_pdata = 32'hF00D;
    rx_rd_en = 1; tx_pop = 1;
    chk("R6 rx data hidden during flush", rx_rdata, 0);
    cyc();
    chk("R5 flush bits clear", ctrl_rdata, 32'hA8);
    chk("R6 both empty after flush", status, 32'h80);
    chk("R6 no udf in flush", rx_udf, 0);
    wr_ctrl(8'h01);                     // rx-only flush, triggers back to 0
    ctrl_wr_en = 1; ctrl_wdata = 8'h00; // R7: a zero flush bit does not cancel it
    cyc();
    chk("R7 trig cleared", ctrl_rdata, 0);
    chk("R5 rx still empty", status, 32'h80);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) tx_put(32'hC000 + i);
    chk("R4 tx full", status, 32'h00);
    chk("R9 no ovf yet", tx_ovf, 0);
    tx_wr_en = 1; tx_wdata = 32'hBAD; cyc();
    chk("R9 ovf pulse", tx_ovf, 1);
    chk("R9 still full", status, 32'h00);
    cyc();
    chk("R9 ovf one cycle", tx_ovf, 0);
    for (int i = 0; i < 8; i++) begin
      chk("R9 stored words intact", tx_rdata, 32'hC000 + i);
      tx_pop = 1; cyc();
    end
    chk("R9 drained", status, 32'h80);
  endtask

  task automatic t_underflow();
    rx_rd_en = 1;
    #1;
    chk("R10 empty read data", rx_rdata, 0);
    cyc();
    chk("R10 udf pulse", rx_udf, 1);
    chk("R10 count unchanged", status, 32'h80);
    cyc();
    chk("R10 udf one cycle", rx_udf, 0);
  endtask

  task automatic t_rx_full();
    for (int i = 0; i < 9; i++) rx_put(32'hE000 + i);
    chk("R11 rx capped", status, 32'h88);
    for (int i = 0; i < 8; i++) begin
      chk("R11 rx words intact", rx_rdata, 32'hE000 + i);
      rx_rd_en = 1; cyc();
    end
    chk("R11 rx drained", status, 32'h80);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    t_reset();
    t_tx_order();
    t_rx_order();
    t_trig();
    t_flush();
    t_overflow();
    t_underflow();
    t_rx_full();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule